// File: doc/BRIEF.md
# Split-Array Successive-Approximation Conversion Controller

This block is the digital sequencer for a 12-bit successive-approximation converter whose capacitive DAC is split into two 6-bit sub-arrays joined by a unit coupling capacitor. It runs each conversion as a fixed frame of fourteen clock periods:

- a tracking period, in which the input is sampled onto the array;
- twelve decision periods, one bit each, starting with the most significant bit;
- a closing period, which presents the finished word with a one-cycle done pulse.

The comparator is a time-domain cell. Two voltage-to-time converters, one on the input side and one on the reference side, produce pulses. A flip-flop reports which pulse ends first, and this controller treats that bit as the decision. The controller raises a comparison strobe during every decision period. While the strobe is low, the time-domain cells precharge.

The DAC level is proportional to lower_count + 64 * upper_count. The trial word therefore maps bit for bit onto the two sub-array switch codes: the upper six bits drive the high-weight array and the lower six bits drive the low-weight array. With the nominal 1.4 MHz clock, the frame yields 100 kS/s.

Top module: `sar_split_ctrl`

## Requirements
- R1: After a conversion starts, the frame lasts exactly 14 cycles: `track_o` is high for one cycle, then `cmp_phase_o` is high for 12 consecutive cycles, then `done_o` is high for one cycle. No two of these three outputs are ever high together.
- R2: The trial word is `{hi_code_o, lo_code_o}`. `hi_code_o` carries word bits 11..6 and `lo_code_o` carries bits 5..0. In the closing period, `result_o` equals that same concatenation.
- R3: Bits are resolved from bit 11 down to bit 0. In the decision period for bit b, bit b of the trial word is 1, the bits below b are 0, and the bits above b hold the decisions already made. Once a trial bit appears in `lo_code_o`, `hi_code_o` does not change for the rest of the frame.
- R4: `cmp_above_i` is sampled at the end of each decision period. A value of 1 means the DAC level is above the input, and the trial bit is cleared. A value of 0 keeps the trial bit. With an ideal comparator, `result_o` equals the sampled input code.
- R5: During the tracking period, both sub-array codes are zero.
- R6: `result_o` changes only on entry to the closing period and holds its value until the next closing period. `done_o` is a single-cycle pulse.
- R7: If `start_i` is high while the controller is idle, or during the closing period, the tracking period begins on the next cycle. A `start_i` during the tracking or decision periods is ignored. If `start_i` is held high, frames run back to back with `done_o` every 14 cycles, so the sample rate is the clock divided by 14.
- R8: A synchronous reset `rst` returns the controller to idle. After the reset edge, both codes, `result_o`, `track_o`, `cmp_phase_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request |
| cmp_above_i | input | 1 | Time-domain decision: 1 when the DAC level is above the input |
| track_o | output | 1 | Input sampling switch control |
| cmp_phase_o | output | 1 | Comparison strobe; low means the time-domain cells precharge |
| hi_code_o | output | 6 | Switch code for the high-weight sub-array |
| lo_code_o | output | 6 | Switch code for the low-weight sub-array |
| result_o | output | 12 | Last completed conversion word |
| done_o | output | 1 | One-cycle pulse marking the closing period |

## Verification
The bound checker checks the following properties on every cycle:

- the three phase outputs are mutually exclusive;
- tracking is followed by a decision period whose only set bit is the top bit;
- the codes are zero while tracking;
- `done_o` is preceded by a decision period and lasts one cycle;
- the result is stable outside `done_o`;
- the upper code is frozen once the lower sub-array is under trial;
- the controller cannot restart during a frame;
- a start in the closing period leads straight into tracking.

Only the bench scenarios can show the remaining behaviours. Those are:

- exact 14-cycle framing;
- the correct trial word in each decision period;
- result equal to the input code, using a behavioural comparator over directed boundary codes and random codes;
- a rate of clock/14 under a held start;
- start requests ignored in mid-frame;
- the effect of a reset in mid-frame.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRACK  = 2'd1,
    ST_DECIDE = 2'd2,
    ST_CLOSE  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_frame_seq.sv
// Frame sequencer: idle -> track -> RES_W decisions -> close.
module sar_frame_seq
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output sar_state_e       st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             enter_track_o,
  output logic             track_o,
  output logic             phase_o
);
  sar_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             track_q, phase_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE:   st_d = start_i ? ST_TRACK : ST_IDLE;
      ST_TRACK: begin
        st_d  = ST_DECIDE;
        idx_d = IDX_W'(RES_W - 1);
      end
      ST_DECIDE: begin
        if (idx_q == '0) st_d = ST_CLOSE;
        else             idx_d = idx_q - 1'b1;
      end
      ST_CLOSE:  st_d = start_i ? ST_TRACK : ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign enter_track_o = (st_d == ST_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      track_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      track_q <= (st_d == ST_TRACK);
      phase_q <= (st_d == ST_DECIDE);
    end
  end

  assign st_o    = st_q;
  assign idx_o   = idx_q;
  assign track_o = track_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/sar_trial_word.sv
// Approximation register: one flop per bit, MSB-first trial-and-keep.
module sar_trial_word
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  sar_state_e       st_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clr_i,
  input  logic             above_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] trial_next_o
);
  logic [RES_W-1:0] trial_q, trial_d;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    always_comb begin
      trial_d[i] = trial_q[i];
      if (clr_i) begin
        trial_d[i] = 1'b0;
      end else if (st_i == ST_TRACK) begin
        if (i == RES_W - 1) trial_d[i] = 1'b1;
      end else if (st_i == ST_DECIDE) begin
        if (idx_i == IDX_W'(i))          trial_d[i] = ~above_i;
        else if (idx_i == IDX_W'(i + 1)) trial_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trial_q <= '0;
    else     trial_q <= trial_d;
  end

  assign trial_o      = trial_q;
  assign trial_next_o = trial_d;
endmodule

// File: rtl/sar_result_reg.sv
// Result register: loads the final word on entry to the closing period.
module sar_result_reg
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  sar_state_e       st_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [RES_W-1:0] word_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  logic             last_bit;
  logic [RES_W-1:0] res_q;
  logic             done_q;

  assign last_bit = (st_i == ST_DECIDE) && (idx_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_bit;
      if (last_bit) res_q <= word_i;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_split_ctrl.sv
module sar_split_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int HI_W = 6,
  parameter int LO_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 cmp_above_i,
  output logic                 track_o,
  output logic                 cmp_phase_o,
  output logic [HI_W-1:0]      hi_code_o,
  output logic [LO_W-1:0]      lo_code_o,
  output logic [HI_W+LO_W-1:0] result_o,
  output logic                 done_o
);
  localparam int RES_W = HI_W + LO_W;
  localparam int IDX_W = $clog2(RES_W + 1);

  sar_state_e       st;
  logic [IDX_W-1:0] idx;
  logic             enter_track;
  logic [RES_W-1:0] trial, trial_next;

  sar_frame_seq #(.RES_W(RES_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .st_o          (st),
    .idx_o         (idx),
    .enter_track_o (enter_track),
    .track_o       (track_o),
    .phase_o       (cmp_phase_o)
  );

  sar_trial_word #(.RES_W(RES_W)) u_trial (
    .clk          (clk),
    .rst          (rst),
    .st_i         (st),
    .idx_i        (idx),
    .clr_i        (enter_track),
    .above_i      (cmp_above_i),
    .trial_o      (trial),
    .trial_next_o (trial_next)
  );

  sar_result_reg #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .st_i     (st),
    .idx_i    (idx),
    .word_i   (trial_next),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign hi_code_o = trial[RES_W-1:LO_W];
  assign lo_code_o = trial[LO_W-1:0];
endmodule

// File: rtl/sar_split_ctrl_chk.sv
module sar_split_ctrl_chk #(
  parameter int HI_W = 6,
  parameter int LO_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic                 track_o,
  input logic                 cmp_phase_o,
  input logic [HI_W-1:0]      hi_code_o,
  input logic [LO_W-1:0]      lo_code_o,
  input logic [HI_W+LO_W-1:0] result_o,
  input logic                 done_o
);
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> !(track_o && cmp_phase_o) && !(track_o && done_o) && !(cmp_phase_o && done_o)); // R1

  AST_DONE_AFTER_DECIDE: assert property (@(posedge clk) disable iff (rst)
    (armed_q && done_o) |-> $past(cmp_phase_o)); // R1

  AST_FIRST_TRIAL_TOP: assert property (@(posedge clk) disable iff (rst)
    (armed_q && track_o) |=> cmp_phase_o && hi_code_o == {1'b1, {(HI_W-1){1'b0}}} && lo_code_o == '0); // R3

  AST_HI_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (armed_q && cmp_phase_o && lo_code_o != '0) |=> $stable(hi_code_o)); // R3

  AST_TRACK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed_q && track_o) |-> hi_code_o == '0 && lo_code_o == '0); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (armed_q && done_o) |=> !done_o); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !done_o) |-> $stable(result_o)); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (track_o || cmp_phase_o)) |=> !track_o); // R7

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (armed_q && done_o && start_i) |=> track_o); // R7
endmodule

bind sar_split_ctrl sar_split_ctrl_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .track_o     (track_o),
  .cmp_phase_o (cmp_phase_o),
  .hi_code_o   (hi_code_o),
  .lo_code_o   (lo_code_o),
  .result_o    (result_o),
  .done_o      (done_o)
);

// File: tb/sar_split_ctrl_bench.sv
`timescale 1ns/1ps
module sar_split_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cmp_above_i;
  logic        track_o, cmp_phase_o, done_o;
  logic [5:0]  hi_code_o, lo_code_o;
  logic [11:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          slot = -1;     // model: -1 idle, 0 track, 1..12 decide, 13 close
  int          vin = 0;       // analog input expressed as a code
  int          vidx = 0;
  int          last_res = 0;
  int          rst_edges = 0;
  int          frame_q[$];

  always #5 clk = ~clk;

  sar_split_ctrl u_sar_split_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_above_i(cmp_above_i),
    .track_o(track_o), .cmp_phase_o(cmp_phase_o), .hi_code_o(hi_code_o),
    .lo_code_o(lo_code_o), .result_o(result_o), .done_o(done_o)
  );

  // Behavioural time-domain comparator: DAC above input -> 1.
  always_comb cmp_above_i = (int'({hi_code_o, lo_code_o}) > vin);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_code(input int n);
    case (n)
      0: return 0;
      1: return 4095;
      2: return 63;
      3: return 64;
      4: return 2048;
      5: return 4032;
      6: return 2047;
      7: return 1;
      default: return int'($urandom & 32'hFFF);
    endcase
  endfunction

  // Reference model of the frame position.
  always @(posedge clk) begin
    if (rst) begin
      slot = -1;
      rst_edges++;
    end else begin
      rst_edges = 0;
      if (slot == -1 || slot == 13) slot = start_i ? 0 : -1;
      else                          slot++;
    end
  end

  always @(negedge clk) begin
    int code;
    int b;
    int expc;
    code = int'({hi_code_o, lo_code_o});
    if (rst) begin
      if (rst_edges >= 1) begin
        chk(track_o == 0 && cmp_phase_o == 0 && done_o == 0, "R8 phase outputs", int'({track_o, cmp_phase_o, done_o}), 0);
        chk(code == 0 && result_o == 0, "R8 codes/result", code + int'(result_o), 0);
      end
      last_res = 0;
      frame_q.delete();
    end else begin
      chk(track_o == (slot == 0), "R1 track", int'(track_o), int'(slot == 0));
      chk(cmp_phase_o == (slot >= 1 && slot <= 12), "R1 phase", int'(cmp_phase_o), int'(slot >= 1 && slot <= 12));
      chk(done_o == (slot == 13), "R6 done", int'(done_o), int'(slot == 13));
      if (slot == 0) begin
        chk(code == 0, "R5 codes zero while tracking", code, 0);
        frame_q.push_back(vin);
      end
      if (slot >= 1 && slot <= 12) begin
        b = 12 - slot;
        expc = (vin & ~((1 << (b + 1)) - 1)) | (1 << b);
        chk(code == expc, "R3 trial word", code, expc);
      end
      if (slot == 13) begin
        expc = (frame_q.size() > 0) ? frame_q.pop_front() : -1;
        chk(int'(result_o) == expc, "R4 result equals input", int'(result_o), expc);
        chk(code == int'(result_o), "R2 codes match result", code, int'(result_o));
        last_res = int'(result_o);
      end else begin
        chk(int'(result_o) == last_res, "R6 result holds", int'(result_o), last_res);
      end
      if (slot == -1 || slot == 13) begin
        vin = next_code(vidx);
        vidx++;
      end
    end
  end

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Single frames with a start request injected mid-frame (R7 ignore).
    for (int f = 0; f < 10; f++) begin
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (14) @(negedge clk);
    end
    // Held start: back-to-back frames, rate clk/14 (R7).
    dones = 0;
    start_i = 1'b1;
    for (int c = 0; c < 280; c++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    start_i = 1'b0;
    chk(dones == 20, "R7 one done per 14 cycles", dones, 20);
    repeat (20) @(negedge clk);
    // Random start pattern.
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk) start_i = (($urandom % 4) == 0);
    end
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    // Reset in mid-frame (R8).
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule